// File: doc/BRIEF.md
# Synchronous Burst Static Memory with Byte-Lane Strobes

This block is a clocked static memory with a synchronous burst interface. An access begins when one of two active-low address strobes is sampled at a rising clock edge. A processor-side strobe is honoured only while the first chip select is low. A controller-side strobe is honoured regardless of that select. The three chip selects are examined only on a strobe edge. When all three are valid, the upper address bits are latched and the two lowest bits seed a two-bit burst counter. The counter then steps in linear order, wrapping from 3 to 0, on every later edge at which the active-low advance input is low. When a strobe finds any select invalid, the device is deselected. It then drives nothing and ignores advance and write controls until the next valid strobe.

The data word has four byte lanes of nine bits each: eight data bits plus one parity bit. Lane A occupies bits 8:0, lane B bits 17:9, lane C bits 26:18 and lane D bits 35:27. A global write stores every lane. Otherwise, the byte-write enable combined with the per-lane selects stores only the chosen lanes. Writes go to the current burst address at a non-strobe edge, before any advance takes effect.

The bidirectional data pins are modelled as three signals: a separate input word, an output word and a drive enable. Output enable acts on the drive combinationally. The drive is also suppressed during the first clock after the device leaves a deselected state.

Top module: `sbsram_core`

The control state machine has four states:
- `ST_IDLE`: the reset state; not selected.
- `ST_DESEL`: deselected by a strobe with invalid selects.
- `ST_FIRST`: the first clock after a valid load out of IDLE or DESEL; the output is masked.
- `ST_BURST`: selected and driving.

Its transitions are:
- IDLE or DESEL to FIRST on a valid strobe.
- IDLE or DESEL to DESEL on an invalid strobe.
- FIRST or BURST to BURST on a valid strobe or on no strobe.
- FIRST or BURST to DESEL on an invalid strobe.

## Requirements
- R1: A rising edge with a taken strobe and valid selects (sel1_n=0, sel2=1, sel3_n=0) loads addr. From then on, dout presents the stored word at that address.
- R2: A taken strobe with any select invalid deselects the device. After that, dq_drive stays 0, and writes and advance have no effect until the next valid strobe.
- R3: strobe_proc_n is ignored while sel1_n is 1. strobe_ctl_n is honoured regardless of sel1_n.
- R4: While selected with no strobe, an edge with adv_n=0 increments the low two address bits linearly, wrapping 3 to 0. The upper address bits do not change.
- R5: gwr_n=0 at a selected, non-strobe edge writes all four lanes, parity included, regardless of bwen_n and bsel_n. Lane k is din[9k+8:9k], with lane A at k=0.
- R6: With gwr_n=1 and bwen_n=0, only lanes whose bsel_n bit is 0 are written, where bsel_n[k] selects lane k. With bwen_n=1, nothing is written.
- R7: oe_n=1 forces dq_drive to 0 combinationally.
- R8: During the first clock after a valid load out of IDLE or DESEL, dq_drive is 0 even with oe_n=0.
- R9: During a write cycle, dq_drive is 0. The write lands at the current burst address, and any advance on the same edge applies afterwards.
- R10: During and straight after reset the device is in IDLE, with dq_drive at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_proc_n | input | 1 | Processor address strobe, active low, gated by sel1_n |
| strobe_ctl_n | input | 1 | Controller address strobe, active low |
| sel1_n | input | 1 | Chip select 1, active low |
| sel2 | input | 1 | Chip select 2, active high |
| sel3_n | input | 1 | Chip select 3, active low |
| addr | input | ADDR_W | Word address |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write, active low |
| bwen_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data at the current burst address |
| dq_drive | output | 1 | High when the data pins would be driven |

## Verification
The hardest situation to reach is the masked first clock. It requires a deselect followed by a valid reload with oe_n held low. The stimulus deselects the device on purpose, through an ungated controller strobe and also through each invalid select in turn. It then reloads an address whose content is already known and shows that the drive appears one clock late. A second subtle case is the ignored processor strobe. Its address differs from the one in use, so a wrongly taken load would change the word that is read back.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_BURST = 2'd2,
        ST_DESEL = 2'd3
    } sb_state_e;
endpackage

// File: rtl/sbsram_addr_ctl.sv
module sbsram_addr_ctl
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_proc_n,
    input  logic              strobe_ctl_n,
    input  logic              sel1_n,
    input  logic              sel2,
    input  logic              sel3_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              adv_n,
    output sb_state_e         state,
    output logic [ADDR_W-3:0] base_up,
    output logic [1:0]        burst_cnt,
    output logic              take,
    output logic              active,
    output logic              mask
);
    localparam int UP_W = ADDR_W - 2;

    sb_state_e       st_q, st_nx;
    logic            valid;
    logic [UP_W-1:0] up_q;
    logic [1:0]      cnt_q;

    // strobe qualification: processor strobe only counts with select 1 low
    always_comb begin
        take  = !strobe_ctl_n || (!strobe_proc_n && !sel1_n);
        valid = !sel1_n && sel2 && !sel3_n;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE, ST_DESEL: begin
                if (take) st_nx = valid ? ST_FIRST : ST_DESEL;
            end
            ST_FIRST, ST_BURST: begin
                if (take) st_nx = valid ? ST_BURST : ST_DESEL;
                else      st_nx = ST_BURST;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_q  <= '0;
            cnt_q <= '0;
        end else if (take && valid) begin
            up_q  <= addr[ADDR_W-1:2];
            cnt_q <= addr[1:0];
        end else if (!take && active && !adv_n) begin
            cnt_q <= cnt_q + 2'd1;
        end
    end

    always_comb begin
        state     = st_q;
        base_up   = up_q;
        burst_cnt = cnt_q;
        active    = (st_q == ST_FIRST) || (st_q == ST_BURST);
        mask      = (st_q == ST_FIRST);
    end
endmodule

// File: rtl/sbsram_wr_dec.sv
module sbsram_wr_dec #(
    parameter int LANES = 4
) (
    input  logic             active,
    input  logic             take,
    input  logic             gwr_n,
    input  logic             bwen_n,
    input  logic [LANES-1:0] bsel_n,
    output logic [LANES-1:0] lane_we,
    output logic             wr_req
);
    always_comb wr_req = !gwr_n || (!bwen_n && (bsel_n != {LANES{1'b1}}));

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        always_comb lane_we[k] = active && !take && (!gwr_n || (!bwen_n && !bsel_n[k]));
    end
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we,
    input  logic [ADDR_W-1:0]       wa,
    input  logic [LANES*LANE_W-1:0] wd,
    input  logic [ADDR_W-1:0]       ra,
    output logic [LANES*LANE_W-1:0] rd
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar k = 0; k < LANES; k++) begin : g_bank
        logic [LANE_W-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (we[k]) mem[wa] <= wd[k*LANE_W +: LANE_W];
        end
        always_comb rd[k*LANE_W +: LANE_W] = mem[ra];
    end
endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    strobe_proc_n,
    input  logic                    strobe_ctl_n,
    input  logic                    sel1_n,
    input  logic                    sel2,
    input  logic                    sel3_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    adv_n,
    input  logic                    gwr_n,
    input  logic                    bwen_n,
    input  logic [LANES-1:0]        bsel_n,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dq_drive
);
    sb_state_e         cur_state;
    logic [ADDR_W-3:0] base_up;
    logic [1:0]        burst_cnt;
    logic              take, active, mask, wr_req;
    logic [LANES-1:0]  lane_we;
    logic [ADDR_W-1:0] cur_addr;

    sbsram_addr_ctl #(.ADDR_W(ADDR_W)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .strobe_proc_n(strobe_proc_n), .strobe_ctl_n(strobe_ctl_n),
        .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
        .addr(addr), .adv_n(adv_n),
        .state(cur_state), .base_up(base_up), .burst_cnt(burst_cnt),
        .take(take), .active(active), .mask(mask)
    );

    sbsram_wr_dec #(.LANES(LANES)) u_wr (
        .active(active), .take(take), .gwr_n(gwr_n), .bwen_n(bwen_n),
        .bsel_n(bsel_n), .lane_we(lane_we), .wr_req(wr_req)
    );

    always_comb cur_addr = {base_up, burst_cnt};

    sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk(clk), .we(lane_we), .wa(cur_addr), .wd(din),
        .ra(cur_addr), .rd(dout)
    );

    // output control: asynchronous enable, masked first clock, off while writing
    always_comb dq_drive = active && !mask && !oe_n && !wr_req;
endmodule

// File: rtl/sbsram_chk.sv
module sbsram_chk
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strobe_proc_n,
    input logic              strobe_ctl_n,
    input logic              sel1_n,
    input logic              sel2,
    input logic              sel3_n,
    input logic [ADDR_W-1:0] addr,
    input logic              adv_n,
    input logic              gwr_n,
    input logic              oe_n,
    input logic              dq_drive,
    input sb_state_e         cur_state,
    input logic [ADDR_W-3:0] base_up,
    input logic [1:0]        burst_cnt
);
    logic              c_take, c_ok, c_sel;
    logic [ADDR_W-3:0] a_up;
    logic [1:0]        a_lo;

    always_comb begin
        c_take = !strobe_ctl_n || (!strobe_proc_n && !sel1_n);
        c_ok   = !sel1_n && sel2 && !sel3_n;
        c_sel  = (cur_state == ST_FIRST) || (cur_state == ST_BURST);
        a_up   = addr[ADDR_W-1:2];
        a_lo   = addr[1:0];
    end

    assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (c_take && c_ok) |=> (base_up == $past(a_up) && burst_cnt == $past(a_lo)));

    assert_desel_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (c_take && !c_ok) |=> !dq_drive);

    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_sel && !c_take && !adv_n) |=> burst_cnt == $past(burst_cnt) + 2'd1);

    assert_upper_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !c_take |=> $stable(base_up));

    assert_oe_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_drive);

    assert_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_state == ST_IDLE || cur_state == ST_DESEL) && c_take && c_ok) |=> !dq_drive);

    assert_wr_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !gwr_n |-> !dq_drive);
endmodule

bind sbsram_core sbsram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .strobe_proc_n(strobe_proc_n), .strobe_ctl_n(strobe_ctl_n),
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .addr(addr), .adv_n(adv_n), .gwr_n(gwr_n), .oe_n(oe_n),
    .dq_drive(dq_drive), .cur_state(cur_state),
    .base_up(base_up), .burst_cnt(burst_cnt)
);

// File: tb/sim_sbsram_core.sv
module sim_sbsram_core;
    localparam int AW = 6;
    localparam int DW = 36;

    logic clk = 0, rst_n = 0;
    logic sp_n, sc_n, s1n, s2, s3n, adv_n, gw_n, bwe_n, oe_n;
    logic [AW-1:0] addr;
    logic [3:0]    bs_n;
    logic [DW-1:0] din, dout;
    logic          drv;

    sbsram_core #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .strobe_proc_n(sp_n), .strobe_ctl_n(sc_n),
        .sel1_n(s1n), .sel2(s2), .sel3_n(s3n), .addr(addr), .adv_n(adv_n),
        .gwr_n(gw_n), .bwen_n(bwe_n), .bsel_n(bs_n), .oe_n(oe_n),
        .din(din), .dout(dout), .dq_drive(drv)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic          e_drv;
        logic [DW-1:0] e_dat;
        string         tag;
    } item_t;

    item_t q[$];
    event  smp;
    int    n_chk = 0, n_bad = 0;
    bit    done = 0;

    // bench model, built from the requirements
    logic [DW-1:0] shadow [1<<AW];
    logic          m_act = 0, m_first = 0;
    logic [AW-3:0] m_up = '0;
    logic [1:0]    m_cnt = '0;

    task automatic idle_inputs();
        sp_n = 1; sc_n = 1; s1n = 0; s2 = 1; s3n = 0; addr = '0;
        adv_n = 1; gw_n = 1; bwe_n = 1; bs_n = 4'hF; oe_n = 0; din = '0;
    endtask

    task automatic cycle(input string tag);
        item_t it;
        logic wr, tk, ok;
        #5;
        wr = !gw_n || (!bwe_n && bs_n != 4'hF);
        it.e_drv = m_act && !m_first && !oe_n && !wr;
        it.e_dat = shadow[{m_up, m_cnt}];
        it.tag   = tag;
        q.push_back(it);
        -> smp;
        @(posedge clk);
        if (rst_n) begin
            tk = !sc_n || (!sp_n && !s1n);
            ok = !s1n && s2 && !s3n;
            if (m_act && !tk)
                for (int k = 0; k < 4; k++)
                    if (!gw_n || (!bwe_n && !bs_n[k]))
                        shadow[{m_up, m_cnt}][9*k +: 9] = din[9*k +: 9];
            if (tk) begin
                if (ok) begin
                    m_first = !m_act; m_act = 1;
                    m_up = addr[AW-1:2]; m_cnt = addr[1:0];
                end else begin
                    m_act = 0; m_first = 0;
                end
            end else begin
                if (m_act && !adv_n) m_cnt = m_cnt + 2'd1;
                m_first = 0;
            end
        end
        @(negedge clk);
    endtask

    // monitor: pop expected item and compare against the pins
    initial begin
        forever begin
            @(smp);
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_chk++;
                if (drv !== it.e_drv) begin
                    n_bad++;
                    $display("FAIL %s: dq_drive=%b expected %b", it.tag, drv, it.e_drv);
                end else if (it.e_drv && dout !== it.e_dat) begin
                    n_bad++;
                    $display("FAIL %s: dout=%h expected %h", it.tag, dout, it.e_dat);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 5000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        finish_run();
    end

    initial begin
        idle_inputs();
        @(negedge clk);
        cycle("R10 reset drive off");
        cycle("R10 reset drive off");
        rst_n = 1;
        cycle("R10 idle after reset");

        // R1/R8: valid load at word 8 from IDLE, then burst global writes
        sc_n = 0; addr = 6'd8;          cycle("R1 load from idle");
        sc_n = 1; adv_n = 0; gw_n = 0; bwe_n = 1; bs_n = 4'hF;
        din = 36'h1_2345_6781;          cycle("R8 masked first clock / R5 R9 write");
        din = 36'h8_9ABC_DEF2;          cycle("R5 R9 global write lane all");
        din = 36'hF_0F0F_0F03;          cycle("R5 R9 global write");
        din = 36'h0_5A5A_5A54;          cycle("R5 R9 write before wrap");
        gw_n = 1; din = '0;
        cycle("R4 wrap read word 8");
        cycle("R4 read word 9");
        cycle("R4 read word 10");
        cycle("R4 read word 11");
        cycle("R4 wrap 3 to 0");
        adv_n = 1;

        // R6: byte writes on lanes A and C only
        sp_n = 0; addr = 6'd9;          cycle("R1 R3 processor strobe load");
        sp_n = 1; bwe_n = 0; bs_n = 4'b1010; din = 36'hA_AAAA_AAAA;
        cycle("R6 byte write lanes A C");
        bwe_n = 1; bs_n = 4'h0; din = 36'h3_3333_3333;
        cycle("R6 bwen high no write");
        bs_n = 4'hF;                    cycle("R6 read merged lanes");
        gw_n = 0; bwe_n = 1; din = 36'h7_1234_5678;
        cycle("R5 global write with selects off");
        gw_n = 1;                       cycle("R5 read global result");

        // R3: processor strobe ignored while sel1_n high
        sp_n = 0; s1n = 1; addr = 6'd40; cycle("R3 ignored strobe");
        sp_n = 1;                       cycle("R3 address kept");
        // R7: output enable high
        oe_n = 1;                       cycle("R7 oe high no drive");
        oe_n = 0;                       cycle("R7 oe low drive back");

        // R2: controller strobe with sel1_n high deselects
        sc_n = 0; addr = 6'd40;         cycle("R2 deselect strobe");
        sc_n = 1; s1n = 0; gw_n = 0; adv_n = 0; din = 36'hF_FFFF_FFFF;
        cycle("R2 write ignored while deselected");
        gw_n = 1;                       cycle("R2 stays quiet");
        adv_n = 1; sc_n = 0; addr = 6'd9; cycle("R8 reload from deselect");
        sc_n = 1;                       cycle("R8 masked first clock");
        cycle("R2 R8 word unchanged");

        // R2: sel2 low, then sel3_n high
        sc_n = 0; s2 = 0;               cycle("R2 sel2 invalid");
        s2 = 1; sc_n = 1;               cycle("R2 quiet after sel2");
        sc_n = 0; addr = 6'd10;         cycle("R1 reload");
        sc_n = 1;                       cycle("R8 mask");
        cycle("R1 read word 10");
        sc_n = 0; s3n = 1;              cycle("R2 sel3 invalid");
        sc_n = 1; s3n = 0;              cycle("R2 quiet after sel3");

        // R9: write then advance in the same edge; new load while active
        sc_n = 0; addr = 6'd20;         cycle("R1 load word 20");
        sc_n = 1; adv_n = 0; gw_n = 0; din = 36'h9_8765_4321;
        cycle("R9 write word 20 then step");
        gw_n = 1; adv_n = 1;            cycle("R8 mask after write cycle end");
        sc_n = 0; addr = 6'd20;         cycle("R9 read word 21 unwritten path");
        sc_n = 1;                       cycle("R1 active reload no mask word 20");
        finish_run();
    end
endmodule